// File: doc/BRIEF.md
# Core Watchdog Timer With Keyed Service

This block is a watchdog for a processor core, clocked by the bus clock. Software reaches it through a single-address-bit register port. One address holds a control/status byte and the other is a write-only service register. Once enabled, a 32-bit counter advances on every clock towards a period chosen by a 3-bit select code. Software prevents a timeout by writing an ordered key pair to the service register. Other accesses may come between the two key writes.

A missed service sets an interrupt flag and raises an interrupt request, which software clears by writing 1 to the flag. A timeout never resets the device. When transfer acknowledge is enabled, a further timeout while the interrupt is still pending produces a one-clock acknowledge pulse and sets a sticky flag. That pulse lets a stalled bus cycle end so the interrupt can be taken.

Top module: `core_wdog`

## Requirements
- R1: After reset the control byte reads 0x00, irqReq and xferAck are low, and the counter stays idle, so no timeout occurs while the enable bit is 0.
- R2: Address 0 is the control byte: bit 7 enable, bit 6 reserved (writes are ignored and it reads 0), bits 5:3 period select, bit 2 acknowledge enable, bit 1 acknowledge-occurred flag, bit 0 interrupt flag. Address 1 is the service register and reads 0x00.
- R3: Select code c gives a period P of 2^(9+2c) clocks for c below 4 and 2^(19+4(c-4)) clocks for c of 4 and above. Counting from the clock edge that writes enable=1, irqReq rises exactly P edges later.
- R4: A timeout sets bit 0 and drives irqReq high. Writing 1 to bit 0 clears both and writing 0 leaves them unchanged. A timeout on the same edge as a clearing write leaves the flag set.
- R5: A service is a 0x55 write followed by a 0xAA write to address 1. Other writes and reads may fall between the two. A 0xAA write that no 0x55 write has armed has no effect on the timeout.
- R6: While armed, another 0x55 write keeps the block armed, and a service-register write of any value other than 0x55 or 0xAA leaves the armed state unchanged.
- R7: A completed service reloads the counter, so the next timeout comes exactly P edges after the 0xAA write edge.
- R8: Writing enable=0 clears the counter and the armed state and keeps both flags. After re-enabling, a lone 0xAA write does not service, and the timeout comes P edges after the enabling edge.
- R9: With bit 2 set, a timeout that finds bit 0 already set produces a one-clock xferAck pulse and sets bit 1. Each further unserviced period pulses again. Writing 1 to bit 1 clears it.
- R10: With bit 2 clear, xferAck never pulses and bit 1 stays 0, however long the interrupt stays pending.
- R11: A select change takes effect at the next compare. If the count has already reached the new period, the timeout fires on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 1 | Register select: 0 control, 1 service |
| regWdata | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irqReq | output | 1 | Interrupt request, high while the interrupt flag is set |
| xferAck | output | 1 | One-clock transfer acknowledge pulse |

## Verification
The period is swept over select codes 0 to 3. Each code is sampled one edge before and at the expected timeout edge, which separates an off-by-one error from a wrong exponent. Key patterns are tried in several forms: a clean pair, a pair with foreign values and extra arm writes between the keys, a lone 0xAA, and a 0x55 followed by a disable. Each of these moves the timeout edge to a different place, so a skipped reload, a lost arm or a stale arm each show up as a different miss. For acknowledge timing, the bench watches the edge of the second and third unserviced periods and compares them with a long window in which the acknowledge is disabled. A collision between a timeout and a flag clear, and a period shrink below the running count, cover the remaining ordering cases.

// File: rtl/core_wdog_pkg.sv
`timescale 1ns/1ps
package core_wdog_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SVC  = 1'b1;

  localparam logic [REG_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [REG_W-1:0] KEY_FIRE = 8'hAA;

  localparam int BIT_EN   = 7;
  localparam int BIT_RSVD = 6;
  localparam int BIT_SELH = 5;
  localparam int BIT_SELL = 3;
  localparam int BIT_XAEN = 2;
  localparam int BIT_XAF  = 1;
  localparam int BIT_IRQF = 0;

  // control -> datapath strobes
  typedef struct packed {
    logic             run;
    logic             reload;
    logic [SEL_W-1:0] sel;
  } wdStrobe_t;

  // exponent of the timeout period for a select code
  function automatic int unsigned periodExp(input logic [SEL_W-1:0] code);
    if (code[2]) return 32'd19 + 32'd4 * 32'(code[1:0]);
    else         return 32'd9  + 32'd2 * 32'(code[1:0]);
  endfunction
endpackage

// File: rtl/core_wdog_dp.sv
`timescale 1ns/1ps
module core_wdog_dp
  import core_wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  wdStrobe_t stb,
  output logic      timeoutStb
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cntNext;
  logic [EXT_W-1:0] limit;

  always_comb begin
    limit      = EXT_W'(1) << periodExp(stb.sel);
    cntNext    = {1'b0, cnt} + EXT_W'(1);
    timeoutStb = stb.run && !stb.reload && (cntNext >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!stb.run || stb.reload || timeoutStb) begin
      cnt <= '0;
    end else begin
      cnt <= cntNext[CNT_W-1:0];
    end
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (cnt == '0)); // R8
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> (cnt == '0)); // R7
  AST_TIMEOUT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    timeoutStb |=> (cnt == '0)); // R3
endmodule

// File: rtl/core_wdog_ctrl.sv
`timescale 1ns/1ps
module core_wdog_ctrl
  import core_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             timeoutStb,
  output wdStrobe_t        stb,
  output logic [REG_W-1:0] ctrlView,
  output logic             irqReq,
  output logic             xferAck
);
  logic             en;
  logic             xaEn;
  logic             xaFlag;
  logic             irqFlag;
  logic             armed;
  logic [SEL_W-1:0] sel;

  logic wrCtrl, wrSvc, keyArm, keyFire, svcDone, xaEvent;

  always_comb begin
    wrCtrl  = regWr && (regAddr == ADDR_CTRL);
    wrSvc   = regWr && (regAddr == ADDR_SVC);
    keyArm  = wrSvc && (regWdata == KEY_ARM);
    keyFire = wrSvc && (regWdata == KEY_FIRE);
    svcDone = en && armed && keyFire;
    xaEvent = timeoutStb && irqFlag && xaEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en      <= 1'b0;
      sel     <= '0;
      xaEn    <= 1'b0;
      xaFlag  <= 1'b0;
      irqFlag <= 1'b0;
      armed   <= 1'b0;
      xferAck <= 1'b0;
    end else begin
      if (wrCtrl) begin
        en   <= regWdata[BIT_EN];
        sel  <= regWdata[BIT_SELH:BIT_SELL];
        xaEn <= regWdata[BIT_XAEN];
      end
      // a new timeout wins over a same-edge clear
      if (timeoutStb)                         irqFlag <= 1'b1;
      else if (wrCtrl && regWdata[BIT_IRQF])  irqFlag <= 1'b0;

      if (xaEvent)                            xaFlag <= 1'b1;
      else if (wrCtrl && regWdata[BIT_XAF])   xaFlag <= 1'b0;

      if (!en)                                armed <= 1'b0;
      else if (keyArm)                        armed <= 1'b1;
      else if (keyFire)                       armed <= 1'b0;

      xferAck <= xaEvent;
    end
  end

  always_comb begin
    stb.run    = en;
    stb.reload = svcDone;
    stb.sel    = sel;
    ctrlView   = {en, 1'b0, sel, xaEn, xaFlag, irqFlag};
    irqReq     = irqFlag;
  end

  AST_XA_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |=> !xferAck); // R9
  AST_XA_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> $past(irqFlag)); // R9
  AST_XA_GATED: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> $past(xaEn)); // R10
  AST_IRQ_FROM_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(timeoutStb)); // R4
  AST_DISARM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !armed); // R8
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWdata[BIT_RSVD]) |=> (ctrlView[BIT_RSVD] == 1'b0)); // R2
endmodule

// File: rtl/core_wdog.sv
`timescale 1ns/1ps
module core_wdog
  import core_wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] rdData,
  output logic             irqReq,
  output logic             xferAck
);
  wdStrobe_t        stb;
  logic             timeoutStb;
  logic [REG_W-1:0] ctrlView;

  core_wdog_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .timeoutStb (timeoutStb),
    .stb        (stb),
    .ctrlView   (ctrlView),
    .irqReq     (irqReq),
    .xferAck    (xferAck)
  );

  core_wdog_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .timeoutStb (timeoutStb)
  );

  assign rdData = (regAddr == ADDR_SVC) ? '0 : ctrlView;
endmodule

// File: tb/core_wdog_tb_top.sv
`timescale 1ns/1ps
module core_wdog_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  wire  [7:0] rdData;
  wire        irqReq;
  wire        xferAck;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  core_wdog dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .rdData(rdData), .irqReq(irqReq), .xferAck(xferAck)
  );

  function automatic int periodOf(input int code);
    if (code < 4) return 1 << (9 + 2 * code);
    return 1 << (19 + 4 * (code - 4));
  endfunction

  function automatic logic [7:0] ctrlByte(input bit en, input int sel, input bit xa,
                                          input bit clrXa, input bit clrIrq);
    logic [2:0] s;
    s = 3'(sel);
    return {en, 1'b0, s, xa, clrXa, clrIrq};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller stands at a negedge; the write lands on the next posedge
  task automatic wrReg(input bit addr, input logic [7:0] d);
    regWr = 1'b1; regAddr = addr; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 1'b0; regWdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int p0;
    p0 = periodOf(0);
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk(rdData == 8'h00, "R1 ctrl after reset", rdData, 0);
    chk(irqReq == 1'b0, "R1 irq after reset", irqReq, 0);
    chk(xferAck == 1'b0, "R1 ack after reset", xferAck, 0);
    idle(p0 + 20);
    chk(irqReq == 1'b0, "R1 no timeout while disabled", irqReq, 0);

    // R2 layout, reserved bit, service readback
    wrReg(0, 8'b0101_1100);
    chk(rdData == 8'h1C, "R2 reserved bit dropped", rdData, 8'h1C);
    regAddr = 1'b1;
    #1;
    chk(rdData == 8'h00, "R2 service reads zero", rdData, 0);
    regAddr = 1'b0;
    idle(1);
    wrReg(0, 8'h00);
    chk(rdData == 8'h00, "R2 ctrl cleared", rdData, 0);

    // R3 period sweep with exact edge
    for (int c = 0; c < 4; c++) begin
      int p;
      p = periodOf(c);
      wrReg(0, ctrlByte(1, c, 0, 0, 0));
      idle(p - 1);
      chk(irqReq == 1'b0, $sformatf("R3 code %0d one edge early", c), irqReq, 0);
      idle(1);
      chk(irqReq == 1'b1, $sformatf("R3 code %0d at period", c), irqReq, 1);
      chk(rdData[0] == 1'b1, $sformatf("R3 code %0d flag bit", c), rdData[0], 1);
      wrReg(0, ctrlByte(0, 0, 0, 0, 1));
      chk(irqReq == 1'b0, "R4 write-one clears irq", irqReq, 0);
    end

    // R4 same-edge set wins, write zero keeps
    wrReg(0, 8'h80);
    idle(p0 - 1);
    wrReg(0, 8'h81);
    chk(irqReq == 1'b1, "R4 timeout beats clear", irqReq, 1);
    wrReg(0, 8'h80);
    chk(irqReq == 1'b1, "R4 write zero keeps flag", irqReq, 1);
    wrReg(0, 8'h81);
    chk(irqReq == 1'b0, "R4 clear after collision", irqReq, 0);
    wrReg(0, 8'h03);

    // R5 + R7 clean service with interleaved accesses
    wrReg(0, 8'h80);
    idle(300);
    wrReg(1, 8'h55);
    wrReg(1, 8'h12);
    wrReg(0, 8'h80);
    idle(5);
    wrReg(1, 8'hAA);
    idle(p0 - 1);
    chk(irqReq == 1'b0, "R7 no timeout before reloaded period", irqReq, 0);
    idle(1);
    chk(irqReq == 1'b1, "R5 R7 timeout one period after service", irqReq, 1);
    wrReg(0, 8'h03);

    // R5 lone 0xAA ignored
    wrReg(0, 8'h80);
    idle(100);
    wrReg(1, 8'hAA);
    idle(p0 - 101 - 1);
    chk(irqReq == 1'b0, "R5 lone AA early edge", irqReq, 0);
    idle(1);
    chk(irqReq == 1'b1, "R5 lone AA does not service", irqReq, 1);
    wrReg(0, 8'h03);

    // R6 foreign value keeps arm
    wrReg(0, 8'h80);
    idle(100);
    wrReg(1, 8'h55);
    wrReg(1, 8'h33);
    wrReg(1, 8'hAA);
    idle(p0 - 1);
    chk(irqReq == 1'b0, "R6 foreign value keeps arm early", irqReq, 0);
    idle(1);
    chk(irqReq == 1'b1, "R6 foreign value keeps arm", irqReq, 1);
    wrReg(0, 8'h03);

    // R6 repeated arm
    wrReg(0, 8'h80);
    idle(200);
    wrReg(1, 8'h55);
    wrReg(1, 8'h55);
    wrReg(1, 8'hAA);
    idle(p0 - 1);
    chk(irqReq == 1'b0, "R6 re-arm early", irqReq, 0);
    idle(1);
    chk(irqReq == 1'b1, "R6 re-arm services", irqReq, 1);
    wrReg(0, 8'h03);

    // R8 disable clears counter and arm, keeps flags
    wrReg(0, 8'h80);
    idle(300);
    wrReg(1, 8'h55);
    wrReg(0, 8'h00);
    wrReg(0, 8'h80);
    wrReg(1, 8'hAA);
    idle(p0 - 2);
    chk(irqReq == 1'b0, "R8 counter restarted from zero", irqReq, 0);
    idle(1);
    chk(irqReq == 1'b1, "R8 arm dropped by disable", irqReq, 1);
    wrReg(0, 8'h00);
    chk(rdData == 8'h01, "R8 flag kept on disable", rdData, 8'h01);
    wrReg(0, 8'h03);

    // R9 acknowledge pulses
    wrReg(0, 8'h84);
    idle(p0);
    chk(irqReq == 1'b1 && xferAck == 1'b0, "R9 first timeout irq only", {irqReq, xferAck}, 2);
    idle(p0 - 1);
    chk(xferAck == 1'b0, "R9 ack not early", xferAck, 0);
    idle(1);
    chk(xferAck == 1'b1, "R9 ack after second period", xferAck, 1);
    chk(rdData[1] == 1'b1, "R9 ack flag set", rdData[1], 1);
    idle(1);
    chk(xferAck == 1'b0, "R9 ack lasts one clock", xferAck, 0);
    idle(p0 - 2);
    chk(xferAck == 1'b0, "R9 third period early", xferAck, 0);
    idle(1);
    chk(xferAck == 1'b1, "R9 ack repeats", xferAck, 1);
    wrReg(0, 8'h86);
    chk(rdData == 8'h85, "R9 write-one clears ack flag", rdData, 8'h85);
    wrReg(0, 8'h03);

    // R10 acknowledge disabled
    begin
      int pulses;
      pulses = 0;
      wrReg(0, 8'h80);
      for (int i = 0; i < 3 * p0 + 10; i++) begin
        idle(1);
        if (xferAck) pulses++;
      end
      chk(pulses == 0, "R10 no pulse when disabled", pulses, 0);
      chk(rdData == 8'h81, "R10 ack flag stays clear", rdData, 8'h81);
      wrReg(0, 8'h03);
    end

    // R11 period shrink below running count
    wrReg(0, ctrlByte(1, 1, 0, 0, 0));
    idle(1000);
    wrReg(0, ctrlByte(1, 0, 0, 0, 0));
    chk(irqReq == 1'b0, "R11 no timeout at select edge", irqReq, 0);
    idle(1);
    chk(irqReq == 1'b1, "R11 shrink fires next edge", irqReq, 1);
    wrReg(0, 8'h03);

    finishRun();
  end
endmodule